// File: doc/BRIEF.md
# Signal Quality Index Capture Unit

This block turns mean-square-error readings from a multi-pair Ethernet receiver into a 3-bit quality index. Index 0 is the poorest signal and 7 the best. Each cable pair delivers an MSE word together with a valid strobe. The block compares that word against a programmable table of seven ascending thresholds. The index is seven minus the number of thresholds the MSE reaches.

Each pair has its own tracking state. It holds the index of the most recent accepted sample. It also holds the lowest index seen since the result register was last read for that pair.

Software works through a small synchronous register port with a control word, a result word and the threshold entries. It writes a capture command that names one pair. The block then latches that pair's current and lowest index into the result word. A later read of the result returns the latched value and restarts the lowest-index tracking for that pair. Sampling only happens while the enable bit is set.

Top module: `sqi_capture_unit`

## Requirements
- R1: The index for an MSE sample is 7 minus the number of thresholds that are less than or equal to the sample (0 worst, 7 best). With the reset thresholds, an MSE of 0 gives 7 and an MSE of 65535 gives 0.
- R2: The seven thresholds sit at addresses 2 to 8, lowest threshold first. They can be written and read back. After reset, threshold k (counting from 0) holds (k+1)*8192.
- R3: Address 0 is the control word and its bit 8 is the enable. While the enable is 0, MSE strobes change neither the current index nor the lowest index of any pair.
- R4: In the control word, bit 15 is the capture command and bits 1:0 select the pair. A read of address 0 returns bit 15 as 0, together with the stored enable and pair select.
- R5: Address 1 is the result word. A capture written while the enable bit in the same write is 1 latches the selected pair's current index into result bits 3:1. Read data appears on the clock edge that samples the read strobe and holds until the next read.
- R6: Result bits 7:5 carry the lowest index the captured pair has produced since its last result read. Each pair tracks this separately.
- R7: A read of the result reloads the lowest-index tracker of the last captured pair with that pair's current index, but only if that capture was enabled.
- R8: A capture written with the enable bit 0 latches 0 into the whole result word and leaves every tracker unchanged.
- R9: Result bit 0 and bits 15:8 always read 0.
- R10: After reset, every tracker holds 7, the result and control words read 0, and the thresholds hold their default values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mse_valid | input | NUM_PAIRS | Per-pair strobe that marks a new MSE sample |
| mse_value | input | NUM_PAIRS*MSE_W | MSE samples packed by pair; pair 0 is in the least significant bits |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
- **MSE strobe:** a strobe updates the pair's tracker on the edge that samples it.
- **Capture write:** a capture write fills the result word on its own edge, so a read issued in the next cycle sees the new value.
- **Read:** read data is registered. It is due on the edge that samples the read strobe, and that same edge reloads the captured pair's lowest-index tracker.

The bench drives every strobe for one cycle and leaves an idle cycle between operations. It samples read data at the falling edge after the sampling edge, so each check lands in the cycle where its result is due.

// File: rtl/sqi_pkg.sv
package sqi_pkg;
   localparam int REG_W     = 16;
   localparam int CTRL_ADDR = 0;
   localparam int RES_ADDR  = 1;
   localparam int THR_BASE  = 2;
   localparam int CAP_BIT   = 15;
   localparam int EN_BIT    = 8;
endpackage

// File: rtl/sqi_index_map.sv
module sqi_index_map #(
   parameter int MSE_W = 16,
   parameter int IDX_W = 3
) (
   input  logic [((1<<IDX_W)-1)*MSE_W-1:0] thr_flat,
   input  logic [MSE_W-1:0]                mse,
   output logic [IDX_W-1:0]                idx
);
   localparam int NUM_THR = (1 << IDX_W) - 1;

   logic [NUM_THR-1:0] hit;
   logic [IDX_W-1:0]   cnt;

   for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
      assign hit[k] = (mse >= thr_flat[k*MSE_W +: MSE_W]);
   end

   always_comb begin
      cnt = '0;
      for (int k = 0; k < NUM_THR; k++) begin
         cnt = cnt + IDX_W'(hit[k]);
      end
      idx = IDX_W'(NUM_THR) - cnt;
   end
endmodule

// File: rtl/sqi_pair_track.sv
module sqi_pair_track #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             sample_valid,
   input  logic [IDX_W-1:0] sample_idx,
   input  logic             reload,
   output logic [IDX_W-1:0] cur_idx,
   output logic [IDX_W-1:0] worst_idx
);
   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   logic             take;
   logic [IDX_W-1:0] cur_nxt;

   assign take    = en && sample_valid;
   assign cur_nxt = take ? sample_idx : cur_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx   <= IDX_MAX;
         worst_idx <= IDX_MAX;
      end else begin
         cur_idx <= cur_nxt;
         if (reload) begin
            worst_idx <= cur_nxt;
         end else if (take && (sample_idx < worst_idx)) begin
            worst_idx <= sample_idx;
         end
      end
   end
endmodule

// File: rtl/sqi_reg_file.sv
module sqi_reg_file
   import sqi_pkg::*;
#(
   parameter int NUM_PAIRS = 4,
   parameter int MSE_W     = 16,
   parameter int IDX_W     = 3,
   parameter int ADDR_W    = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                reg_wr,
   input  logic                                reg_rd,
   input  logic [ADDR_W-1:0]                   reg_addr,
   input  logic [REG_W-1:0]                    reg_wdata,
   input  logic [NUM_PAIRS*IDX_W-1:0]          cur_flat,
   input  logic [NUM_PAIRS*IDX_W-1:0]          worst_flat,
   output logic                                sqi_en,
   output logic [((1<<IDX_W)-1)*MSE_W-1:0]     thr_flat,
   output logic [NUM_PAIRS-1:0]                reload,
   output logic [REG_W-1:0]                    reg_rdata
);
   localparam int NUM_THR = (1 << IDX_W) - 1;
   localparam int PAIR_W  = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
   localparam int WST_LSB = IDX_W + 2;

   if (MSE_W > REG_W || MSE_W < IDX_W) begin : g_bad_mse
      $error("MSE_W must lie between IDX_W and the register width");
   end
   if (WST_LSB + IDX_W > EN_BIT) begin : g_bad_idx
      $error("IDX_W too wide for the result layout");
   end
   if (PAIR_W > EN_BIT || NUM_PAIRS != (1 << PAIR_W)) begin : g_bad_pairs
      $error("NUM_PAIRS must be a power of two that fits below the enable bit");
   end
   if (THR_BASE + NUM_THR > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the threshold table");
   end

   logic                en_q;
   logic [PAIR_W-1:0]   sel_q;
   logic [PAIR_W-1:0]   cap_pair_q;
   logic                cap_live_q;
   logic [REG_W-1:0]    res_q;
   logic [REG_W-1:0]    rdata_q;
   logic [REG_W-1:0]    res_nxt;
   logic [REG_W-1:0]    rd_nxt;
   logic [MSE_W-1:0]    thr_q [NUM_THR];

   logic                wr_ctrl;
   logic                cap_cmd;
   logic                cap_on;
   logic                rd_res;
   logic [PAIR_W-1:0]   sel_w;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
   assign cap_cmd = wr_ctrl && reg_wdata[CAP_BIT];
   assign cap_on  = reg_wdata[EN_BIT];
   assign rd_res  = reg_rd && (reg_addr == ADDR_W'(RES_ADDR));
   assign sel_w   = reg_wdata[PAIR_W-1:0];

   always_comb begin
      res_nxt = '0;
      res_nxt[1 +: IDX_W]       = cur_flat[int'(sel_w)*IDX_W +: IDX_W];
      res_nxt[WST_LSB +: IDX_W] = worst_flat[int'(sel_w)*IDX_W +: IDX_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         sel_q      <= '0;
         cap_pair_q <= '0;
         cap_live_q <= 1'b0;
         res_q      <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q  <= cap_on;
            sel_q <= sel_w;
         end
         if (cap_cmd) begin
            cap_pair_q <= sel_w;
            cap_live_q <= cap_on;
            res_q      <= cap_on ? res_nxt : '0;
         end
      end
   end

   for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
      localparam logic [MSE_W-1:0] THR_DEF = MSE_W'(k + 1) << (MSE_W - IDX_W);
      logic wr_thr;
      assign wr_thr = reg_wr && (reg_addr == ADDR_W'(THR_BASE + k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            thr_q[k] <= THR_DEF;
         end else if (wr_thr) begin
            thr_q[k] <= reg_wdata[MSE_W-1:0];
         end
      end
      assign thr_flat[k*MSE_W +: MSE_W] = thr_q[k];
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_reload
      assign reload[p] = rd_res && cap_live_q && (cap_pair_q == PAIR_W'(p));
   end

   always_comb begin
      rd_nxt = '0;
      if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
         rd_nxt[EN_BIT]       = en_q;
         rd_nxt[PAIR_W-1:0]   = sel_q;
      end else if (reg_addr == ADDR_W'(RES_ADDR)) begin
         rd_nxt = res_q;
      end
      for (int k = 0; k < NUM_THR; k++) begin
         if (reg_addr == ADDR_W'(THR_BASE + k)) begin
            rd_nxt = REG_W'(thr_q[k]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (reg_rd) begin
         rdata_q <= rd_nxt;
      end
   end

   assign sqi_en    = en_q;
   assign reg_rdata = rdata_q;
endmodule

// File: rtl/sqi_capture_unit.sv
module sqi_capture_unit
   import sqi_pkg::*;
#(
   parameter int NUM_PAIRS = 4,
   parameter int MSE_W     = 16,
   parameter int IDX_W     = 3,
   parameter int ADDR_W    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PAIRS-1:0]         mse_valid,
   input  logic [NUM_PAIRS*MSE_W-1:0]   mse_value,
   input  logic                         reg_wr,
   input  logic                         reg_rd,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [15:0]                  reg_wdata,
   output logic [15:0]                  reg_rdata
);
   localparam int NUM_THR = (1 << IDX_W) - 1;

   if (NUM_PAIRS < 1) begin : g_bad_n
      $error("NUM_PAIRS must be at least 1");
   end

   logic                         sqi_en;
   logic [NUM_THR*MSE_W-1:0]     thr_flat;
   logic [NUM_PAIRS-1:0]         reload;
   logic [NUM_PAIRS*IDX_W-1:0]   cur_flat;
   logic [NUM_PAIRS*IDX_W-1:0]   worst_flat;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic [IDX_W-1:0] samp_idx;

      sqi_index_map #(.MSE_W(MSE_W), .IDX_W(IDX_W)) u_map (
         .thr_flat (thr_flat),
         .mse      (mse_value[p*MSE_W +: MSE_W]),
         .idx      (samp_idx)
      );

      sqi_pair_track #(.IDX_W(IDX_W)) u_track (
         .clk          (clk),
         .rst_n        (rst_n),
         .en           (sqi_en),
         .sample_valid (mse_valid[p]),
         .sample_idx   (samp_idx),
         .reload       (reload[p]),
         .cur_idx      (cur_flat[p*IDX_W +: IDX_W]),
         .worst_idx    (worst_flat[p*IDX_W +: IDX_W])
      );
   end

   sqi_reg_file #(
      .NUM_PAIRS (NUM_PAIRS),
      .MSE_W     (MSE_W),
      .IDX_W     (IDX_W),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .cur_flat   (cur_flat),
      .worst_flat (worst_flat),
      .sqi_en     (sqi_en),
      .thr_flat   (thr_flat),
      .reload     (reload),
      .reg_rdata  (reg_rdata)
   );
endmodule

// File: rtl/sqi_capture_unit_chk.sv
module sqi_capture_unit_chk #(
   parameter int NUM_PAIRS = 4,
   parameter int IDX_W     = 3,
   parameter int ADDR_W    = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       reg_wr,
   input logic                       reg_rd,
   input logic [ADDR_W-1:0]          reg_addr,
   input logic                       cap_bit,
   input logic                       en_bit,
   input logic [15:0]                reg_rdata,
   input logic                       sqi_en,
   input logic [NUM_PAIRS*IDX_W-1:0] cur_flat,
   input logic [NUM_PAIRS*IDX_W-1:0] worst_flat
);
   localparam int PAD_LSB = 2*IDX_W + 2;

   p_cap_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(0)) |=> (reg_rdata[15] == 1'b0));

   p_result_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(1)) |=>
         (reg_rdata[0] == 1'b0 && (reg_rdata >> PAD_LSB) == 16'h0));

   p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   p_frozen_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sqi_en |=> $stable(cur_flat));

   p_off_capture_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(0) && cap_bit && !en_bit)
      ##1 (reg_rd && !reg_wr && reg_addr == ADDR_W'(1)) |=> (reg_rdata == 16'h0));

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pp
      p_worst_not_above_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
         worst_flat[p*IDX_W +: IDX_W] <= cur_flat[p*IDX_W +: IDX_W]);
   end
endmodule

bind sqi_capture_unit sqi_capture_unit_chk #(
   .NUM_PAIRS (NUM_PAIRS),
   .IDX_W     (IDX_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .cap_bit    (reg_wdata[15]),
   .en_bit     (reg_wdata[8]),
   .reg_rdata  (reg_rdata),
   .sqi_en     (sqi_en),
   .cur_flat   (cur_flat),
   .worst_flat (worst_flat)
);

// File: tb/sqi_capture_unit_bench.sv
module sqi_capture_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP  = 4;
   localparam int MW  = 16;
   localparam int AW  = 4;
   localparam int NVEC = 10;

   // {pair[1:0], mse[15:0], expected index[2:0]} under reset thresholds
   localparam logic [20:0] VEC [NVEC] = '{
      {2'd0, 16'd0,     3'd7},
      {2'd1, 16'd8191,  3'd7},
      {2'd2, 16'd8192,  3'd6},
      {2'd3, 16'd16384, 3'd5},
      {2'd0, 16'd30000, 3'd4},
      {2'd1, 16'd40960, 3'd2},
      {2'd2, 16'd57344, 3'd0},
      {2'd3, 16'd65535, 3'd0},
      {2'd0, 16'd49151, 3'd2},
      {2'd1, 16'd49152, 3'd1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    mse_valid = '0;
   logic [NP*MW-1:0] mse_value = '0;
   logic             reg_wr = 1'b0;
   logic             reg_rd = 1'b0;
   logic [AW-1:0]    reg_addr = '0;
   logic [15:0]      reg_wdata = '0;
   logic [15:0]      reg_rdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sqi_capture_unit #(.NUM_PAIRS(NP), .MSE_W(MW), .IDX_W(3), .ADDR_W(AW)) u_sqi_capture_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .mse_valid (mse_valid),
      .mse_value (mse_value),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [15:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [15:0] data);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = AW'(addr);
      @(negedge clk);
      reg_rd = 1'b0;
      data = reg_rdata;
   endtask

   task automatic send(input int pair, input logic [15:0] mse);
      @(negedge clk);
      mse_valid[pair] = 1'b1;
      mse_value[pair*MW +: MW] = mse;
      @(negedge clk);
      mse_valid = '0;
   endtask

   // capture pair with enable set, then read the result word
   task automatic grab(input int pair, output logic [15:0] data);
      wr(0, 16'h8100 | 16'(pair));
      rd(1, data);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [15:0] hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 / R2 reset state
      rd(1, d);  check("R10 result after reset", d, 16'h0000);
      rd(0, d);  check("R10 control after reset", d, 16'h0000);
      rd(2, d);  check("R2 threshold 0 default", d, 16'd8192);
      rd(8, d);  check("R2 threshold 6 default", d, 16'd57344);
      grab(1, d); check("R10 tracker reset value", d, 16'h00EE);

      // R1 / R5 / R9 table walk
      wr(0, 16'h0100);
      for (int i = 0; i < NVEC; i++) begin
         send(int'(VEC[i][20:19]), VEC[i][18:3]);
         grab(int'(VEC[i][20:19]), d);
         check("R1 R5 current index", {13'b0, d[3:1]}, {13'b0, VEC[i][2:0]});
         check("R9 padding bits", {d[15:8], 7'b0, d[0]}, 16'h0000);
      end

      // R6 lowest index since last read; pair 2 last held index 0
      send(2, 16'd0);
      grab(2, d); check("R6 worst carries earlier low", d, 16'h000E);
      send(2, 16'd40000);
      send(2, 16'd100);
      grab(2, d); check("R6 worst after dip", d, 16'h006E);
      // R7 the read above reloaded the tracker with the current index
      grab(2, d); check("R7 reload after read", d, 16'h00EE);

      // R3 samples ignored while disabled
      wr(0, 16'h0002);
      send(2, 16'd65535);
      grab(2, d); check("R3 disabled sample ignored", d, 16'h00EE);

      // R8 disabled capture gives zero and keeps trackers
      send(2, 16'd40000);
      send(2, 16'd100);
      wr(0, 16'h8002);
      rd(1, d); check("R8 disabled capture result", d, 16'h0000);
      grab(2, d); check("R8 trackers unchanged", d, 16'h006E);

      // R4 control readback
      rd(0, d); check("R4 control readback", d, 16'h0102);

      // R2 reprogrammed thresholds 100..700
      for (int k = 0; k < 7; k++) wr(2 + k, 16'(100 * (k + 1)));
      rd(5, d); check("R2 threshold readback", d, 16'd400);
      send(1, 16'd350);
      grab(1, d); check("R2 R1 custom table mid", {13'b0, d[3:1]}, 16'd4);
      send(1, 16'd700);
      grab(1, d); check("R2 R1 custom table top", {13'b0, d[3:1]}, 16'd0);

      // R5 read data holds without a read strobe
      hold = d;
      repeat (4) @(negedge clk);
      check("R5 read data holds", reg_rdata, hold);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule